// File: doc/BRIEF.md
# Masked Bus-Match Debug Comparator

This block watches every cycle of a CPU bus and raises a one-cycle trigger when the cycle hits a programmed address. The trigger can also be made to depend on the data word, with a separate enable for each data bit, and on the direction and size of the access. The trigger goes to a separate sequencing block, together with a flag that says whether the hit counts as forced or tagged.

Software sets the block up through a small byte-wide register port while the debug logic is disarmed. When the `arm` input is high, that port is locked and the comparator is live. When `arm` is low, the comparator never fires.

Top module: `bus_match_cmp`

## Requirements
- R1: All registers and both outputs are zero after reset. The map is byte-wide: offset 0 is control, 1 and 2 are the address compare low and high, 3 and 4 are the data compare low (bits 7:0) and high (bits 15:8), and 5 and 6 are the data mask low and high. Control bits: 0 = data compare enable, 1 = tag mode, 2 = direction qualify enable, 3 = required direction (1 = read), 4 = size qualify enable, 5 = required size (1 = word). A fresh configuration therefore compares the address only.
- R2: If a cycle has `bus_valid` high and meets every enabled condition, `match_pulse` is high for exactly the next clock cycle. An address different from the compare address, or `bus_valid` low, gives no pulse.
- R3: No pulse is produced while `arm` is low.
- R4: With data compare enabled and tag mode clear, a data bit whose mask bit is 1 must equal its compare bit. A data bit whose mask bit is 0 is ignored.
- R5: When tag mode is set, data is not compared. In that mode `match_tagged` is high together with every pulse. When tag mode is clear, `match_tagged` stays low (forced type).
- R6: With direction qualify enabled, a hit also needs `bus_rnw` to equal the required direction bit.
- R7: With size qualify enabled, a hit also needs `bus_word` to equal the required size bit.
- R8: A word access compares all 16 data bits. A byte access compares one lane only, using that lane's mask. Address bit 0 = 0 selects bits 15:8, and address bit 0 = 1 selects bits 7:0.
- R9: A register write made while `arm` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Enables matching and locks configuration |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | 16 | Bus data |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| match_pulse | output | 1 | Registered one-cycle hit trigger |
| match_tagged | output | 1 | Hit type: 1 = tagged, 0 = forced |

## Verification
The assertions check on every cycle that:
- no pulse follows an idle or disarmed cycle;
- any pulse came from a cycle whose address equalled the compare address and which met every enabled qualifier;
- the tagged flag appears only with a pulse;
- the configuration does not change during an armed write.

Only the bench scenarios can show the positive side. These are: a hit really fires, the per-bit mask ignores exactly the bits it clears, byte-lane selection follows address bit 0, and tag mode switches the data compare off.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
   localparam int DATA_W  = 16;
   localparam int LANES   = DATA_W / 8;
   localparam int REG_AW  = 3;

   localparam logic [REG_AW-1:0] RA_CTRL    = 3'd0;
   localparam logic [REG_AW-1:0] RA_ADDR_LO = 3'd1;
   localparam logic [REG_AW-1:0] RA_ADDR_HI = 3'd2;
   localparam logic [REG_AW-1:0] RA_DATA_LO = 3'd3;
   localparam logic [REG_AW-1:0] RA_DATA_HI = 3'd4;
   localparam logic [REG_AW-1:0] RA_MASK_LO = 3'd5;
   localparam logic [REG_AW-1:0] RA_MASK_HI = 3'd6;

   // control register layout, bit 0 last
   typedef struct packed {
      logic size_word;
      logic size_en;
      logic dir_read;
      logic dir_en;
      logic tag_mode;
      logic data_en;
   } ctrl_t;
endpackage

// File: rtl/bmc_cfg_regs.sv
module bmc_cfg_regs
   import bmc_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output ctrl_t             ctrl,
   output logic [ADDR_W-1:0] cmp_addr,
   output logic [DATA_W-1:0] cmp_data,
   output logic [DATA_W-1:0] cmp_mask
);
   logic [15:0] addr_r;
   logic        wr_ok;

   assign wr_ok = wr_en && !lock;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl     <= '0;
         addr_r   <= '0;
         cmp_data <= '0;
         cmp_mask <= '0;
      end else if (wr_ok) begin
         case (wr_addr)
            RA_CTRL:    ctrl           <= ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
            RA_ADDR_LO: addr_r[7:0]    <= wr_data;
            RA_ADDR_HI: addr_r[15:8]   <= wr_data;
            RA_DATA_LO: cmp_data[7:0]  <= wr_data;
            RA_DATA_HI: cmp_data[15:8] <= wr_data;
            RA_MASK_LO: cmp_mask[7:0]  <= wr_data;
            RA_MASK_HI: cmp_mask[15:8] <= wr_data;
            default: ;
         endcase
      end
   end

   assign cmp_addr = addr_r[ADDR_W-1:0];

   generate
      if (ADDR_W < 16) begin : g_unused_hi
         logic unused_hi;
         assign unused_hi = ^addr_r[15:ADDR_W];
      end
   endgenerate
endmodule

// File: rtl/bmc_data_match.sv
module bmc_data_match
   import bmc_pkg::*;
(
   input  logic [DATA_W-1:0] bus_data,
   input  logic [DATA_W-1:0] cmp_data,
   input  logic [DATA_W-1:0] cmp_mask,
   input  logic              word_acc,
   input  logic              odd_addr,
   output logic              data_hit
);
   logic [LANES-1:0] lane_ok;
   logic [LANES-1:0] lane_used;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         // lane 0 (bits 7:0) is the odd byte, lane 1 (bits 15:8) the even byte
         localparam logic SEL_ODD = (g == 0);
         logic [7:0] diff;
         assign diff         = (bus_data[g*8 +: 8] ^ cmp_data[g*8 +: 8]) & cmp_mask[g*8 +: 8];
         assign lane_ok[g]   = (diff == 8'h00);
         assign lane_used[g] = word_acc || (odd_addr == SEL_ODD);
      end
   endgenerate

   assign data_hit = &(lane_ok | ~lane_used);
endmodule

// File: rtl/bmc_qualify.sv
module bmc_qualify
   import bmc_pkg::*;
(
   input  ctrl_t ctrl,
   input  logic  addr_hit,
   input  logic  data_hit,
   input  logic  rnw,
   input  logic  word_acc,
   output logic  hit
);
   logic data_ok, dir_ok, size_ok;

   always_comb begin
      data_ok = !(ctrl.data_en && !ctrl.tag_mode) || data_hit;
      dir_ok  = !ctrl.dir_en  || (rnw == ctrl.dir_read);
      size_ok = !ctrl.size_en || (word_acc == ctrl.size_word);
      hit     = addr_hit && data_ok && dir_ok && size_ok;
   end
endmodule

// File: rtl/bus_match_cmp.sv
module bus_match_cmp
   import bmc_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [7:0]        cfg_wdata,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [15:0]       bus_data,
   input  logic              bus_rnw,
   input  logic              bus_word,
   output logic              match_pulse,
   output logic              match_tagged
);
   generate
      if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_aw
         $error("bus_match_cmp: ADDR_W must lie in 2..16");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic [ADDR_W-1:0] cmp_addr_q;
   logic [DATA_W-1:0] cmp_data_q;
   logic [DATA_W-1:0] mask_q;
   logic              data_hit;
   logic              hit;

   bmc_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock     (arm),
      .wr_en    (cfg_we),
      .wr_addr  (cfg_addr),
      .wr_data  (cfg_wdata),
      .ctrl     (ctrl_q),
      .cmp_addr (cmp_addr_q),
      .cmp_data (cmp_data_q),
      .cmp_mask (mask_q)
   );

   bmc_data_match u_data (
      .bus_data (bus_data),
      .cmp_data (cmp_data_q),
      .cmp_mask (mask_q),
      .word_acc (bus_word),
      .odd_addr (bus_addr[0]),
      .data_hit (data_hit)
   );

   bmc_qualify u_qual (
      .ctrl     (ctrl_q),
      .addr_hit (bus_addr == cmp_addr_q),
      .data_hit (data_hit),
      .rnw      (bus_rnw),
      .word_acc (bus_word),
      .hit      (hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_pulse  <= 1'b0;
         match_tagged <= 1'b0;
      end else begin
         match_pulse  <= arm && bus_valid && hit;
         match_tagged <= arm && bus_valid && hit && ctrl_q.tag_mode;
      end
   end
endmodule

// File: rtl/bus_match_cmp_chk.sv
module bus_match_cmp_chk
   import bmc_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              arm,
   input logic              cfg_we,
   input logic              bus_valid,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rnw,
   input logic              bus_word,
   input logic              match_pulse,
   input logic              match_tagged,
   input ctrl_t             ctrl,
   input logic [ADDR_W-1:0] cmp_addr,
   input logic [ADDR_W+$bits(ctrl_t)+2*DATA_W-1:0] cfg_flat
);
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> !match_pulse);

   p_addr_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> ($past(bus_addr) == $past(cmp_addr)));

   p_disarmed_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> !match_pulse);

   p_kind_needs_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      match_tagged |-> match_pulse);

   p_dir_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (match_pulse && $past(ctrl.dir_en)) |-> ($past(bus_rnw) == $past(ctrl.dir_read)));

   p_size_qual_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (match_pulse && $past(ctrl.size_en)) |-> ($past(bus_word) == $past(ctrl.size_word)));

   p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && cfg_we) |=> $stable(cfg_flat));
endmodule

bind bus_match_cmp bus_match_cmp_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .arm          (arm),
   .cfg_we       (cfg_we),
   .bus_valid    (bus_valid),
   .bus_addr     (bus_addr),
   .bus_rnw      (bus_rnw),
   .bus_word     (bus_word),
   .match_pulse  (match_pulse),
   .match_tagged (match_tagged),
   .ctrl         (ctrl_q),
   .cmp_addr     (cmp_addr_q),
   .cfg_flat     ({ctrl_q, cmp_addr_q, cmp_data_q, mask_q})
);

// File: tb/tb_bus_match_cmp.sv
`timescale 1ns/1ps
module tb_bus_match_cmp;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        bus_valid = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [15:0] bus_data = '0;
   logic        bus_rnw = 1'b0;
   logic        bus_word = 1'b1;
   logic        match_pulse, match_tagged;

   int checks = 0;
   int failures = 0;
   logic [1:0] q_exp[$];
   string      q_req[$];

   always #2.5 clk = ~clk;

   bus_match_cmp dut (.*);

   // monitor: scoreboard pops one expected item per clock
   always @(negedge clk) begin
      if (q_exp.size() > 0) begin
         logic [1:0] e;
         string r;
         e = q_exp.pop_front();
         r = q_req.pop_front();
         checks++;
         if ({match_pulse, match_tagged} !== e) begin
            failures++;
            $display("FAIL %s pulse/tag actual=%b expected=%b", r, {match_pulse, match_tagged}, e);
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_valid = 1'b0; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_arm(input logic v);
      @(negedge clk);
      bus_valid = 1'b0; arm = v;
   endtask

   task automatic cyc(input logic [15:0] a, input logic [15:0] d, input logic rnw,
                      input logic word, input logic valid, input logic ep,
                      input logic et, input string rq);
      @(negedge clk);
      bus_valid = valid; bus_addr = a; bus_data = d; bus_rnw = rnw; bus_word = word;
      @(posedge clk);
      #1;
      q_exp.push_back({ep, et});
      q_req.push_back(rq);
   endtask

   task automatic summary;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      #(5.0 * 100000);
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if ({match_pulse, match_tagged} !== 2'b00) begin
         failures++;
         $display("FAIL R1 reset outputs actual=%b expected=00", {match_pulse, match_tagged});
      end
      rst_n = 1'b1;

      wr(3'd1, 8'h34); wr(3'd2, 8'h12);
      cyc(16'h1234, 16'h0000, 1, 1, 1, 0, 0, "R3 disarmed");
      set_arm(1);
      cyc(16'h1234, 16'hBEEF, 0, 0, 1, 1, 0, "R1 address-only after reset");
      cyc(16'h1234, 16'h0000, 1, 1, 1, 1, 0, "R2 address hit");
      cyc(16'h1235, 16'h0000, 1, 1, 1, 0, 0, "R2 address miss");
      cyc(16'h1234, 16'h0000, 1, 1, 0, 0, 0, "R2 valid low");

      // R4: per-bit mask
      set_arm(0);
      wr(3'd3, 8'hC3); wr(3'd4, 8'hA5); wr(3'd5, 8'h0F); wr(3'd6, 8'hF0); wr(3'd0, 8'h01);
      set_arm(1);
      cyc(16'h1234, 16'hA5C3, 1, 1, 1, 1, 0, "R4 exact data");
      cyc(16'h1234, 16'hAFC3, 1, 1, 1, 1, 0, "R4 masked-off bits differ");
      cyc(16'h1234, 16'hA5C2, 1, 1, 1, 0, 0, "R4 enabled bit 0 differs");
      cyc(16'h1234, 16'h55C3, 1, 1, 1, 0, 0, "R4 enabled high bits differ");
      // R8: byte lanes
      cyc(16'h1234, 16'hA0FF, 1, 0, 1, 1, 0, "R8 even byte uses bits 15:8");
      cyc(16'h1234, 16'h50C3, 1, 0, 1, 0, 0, "R8 even byte mismatch in high lane");
      set_arm(0);
      wr(3'd1, 8'h35);
      set_arm(1);
      cyc(16'h1235, 16'h00C3, 1, 0, 1, 1, 0, "R8 odd byte uses bits 7:0");
      cyc(16'h1235, 16'h00C2, 1, 0, 1, 0, 0, "R8 odd byte mismatch in low lane");

      // R5: tag mode
      set_arm(0);
      wr(3'd0, 8'h03);
      set_arm(1);
      cyc(16'h1235, 16'h0000, 1, 1, 1, 1, 1, "R5 tag mode ignores data");

      // R6: direction
      set_arm(0);
      wr(3'd0, 8'h0C);
      set_arm(1);
      cyc(16'h1235, 16'h0000, 1, 1, 1, 1, 0, "R6 read matches");
      cyc(16'h1235, 16'h0000, 0, 1, 1, 0, 0, "R6 write rejected");

      // R7: size
      set_arm(0);
      wr(3'd0, 8'h30);
      set_arm(1);
      cyc(16'h1235, 16'h0000, 0, 1, 1, 1, 0, "R7 word matches");
      cyc(16'h1235, 16'h0000, 0, 0, 1, 0, 0, "R7 byte rejected");

      // R9: writes while armed ignored
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h00);
      cyc(16'h1235, 16'h0000, 0, 1, 1, 1, 0, "R9 old address kept");
      cyc(16'h1200, 16'h0000, 0, 1, 1, 0, 0, "R9 new address refused");
      cyc(16'h1235, 16'h0000, 0, 0, 1, 0, 0, "R9 old size qualifier kept");

      @(negedge clk);
      bus_valid = 1'b0;
      while (q_exp.size() > 0) @(negedge clk);
      @(negedge clk);
      summary();
      $finish;
   end
endmodule